// File: doc/BRIEF.md
# Framed Command Register-Write Decoder

This block sits behind a byte receiver and turns a stream of framed command packets into register writes. A packet opens with a fixed five-byte header. It carries any number of two-byte command words and closes with a single terminator byte. Each command word packs a 4-bit register address and an 8-bit value into 16 bits. Two check bits in the word hold inverted copies of value bits, and the decoder checks them before it trusts the word.

Every accepted word produces a one-cycle write strobe. The strobe carries the active bank, the address and the value, and goes to a banked register file outside the block. Two addresses are decoded locally in every bank. Address 15 selects the bank and the slow clock mode. Address 14 is the control register: it produces one-cycle pulses for capture-FSM reset, arm and ADC reset, and it holds the LED and ADC-enable levels.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After reset, `wr_en` and all three pulse outputs are 0. `bank`, `slow_mode`, `led` and `adc_en` are also 0.
- R2: Words are accepted only after the header bytes 0x40, 0x4C, 0x44, 0x53, 0x7E have arrived in that order. A byte that breaks the order restarts the search. The search restarts at the second header position if that byte is 0x40, and at the first position otherwise. No write is issued while the decoder is searching.
- R3: A command word arrives high byte first. In the 16-bit word, value bits [5:0] sit at word bits [5:0], value bits 7:6 sit at word bits 13:12, and the address sits at word bits [11:8].
- R4: A word is discarded unless all of the following hold: word bit 6 equals the inverse of value bit 5, word bit 14 equals the inverse of value bit 7, and word bits 7 and 15 are 0. A discarded word issues no write, and decoding continues with the next word of the same packet.
- R5: The byte 0x7E in a high-byte position ends the packet. The bytes that follow are then treated as a header search.
- R6: Every accepted word, including words to addresses 14 and 15, raises `wr_en` for exactly one cycle. The strobe comes in the cycle after the clock edge that takes the low byte. In that cycle `wr_bank`, `wr_addr` and `wr_data` carry the bank, the address and the value.
- R7: A write to address 15, in any bank, loads `bank` from value bits [1:0] and `slow_mode` from value bit 5. The `wr_bank` of that same strobe shows the bank that was in effect before the write.
- R8: A write to address 14, in any bank, produces one-cycle pulses on `fsm_rst_p` (value bit 0), `arm_p` (bit 1) and `adc_rst_p` (bit 6), alongside the strobe. The same write loads the levels `led` (bit 7) and `adc_en` (bit 4).
- R9: A byte is taken only in a cycle where `rx_valid` is 1. While `rx_valid` is 0, changes on `rx_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_data | input | 8 | Received byte |
| wr_en | output | 1 | One-cycle write strobe |
| wr_bank | output | 2 | Bank of the write |
| wr_addr | output | 4 | Register address of the write |
| wr_data | output | 8 | Value of the write |
| bank | output | 2 | Currently selected bank |
| slow_mode | output | 1 | Slow clock mode level |
| led | output | 1 | LED level |
| adc_en | output | 1 | ADC enable level |
| fsm_rst_p | output | 1 | Capture-FSM reset pulse |
| arm_p | output | 1 | Arm pulse |
| adc_rst_p | output | 1 | ADC reset pulse |

## Verification
Random packets carry random addresses and values, and some words have one check or zero bit flipped. These packets separate the bit placement of the encoding from the rejection logic. A random byte occasionally replaces a header byte, and idle cycles with changing `rx_data` are mixed in between bytes. These cases test that a broken header and unqualified bytes have no effect. Directed sequences cover the 0x40 resynchronisation and a terminator followed by word-like bytes. They also cover a bank switch before a write and a control write with all bits set, which shows the pulse and level split.

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       wr_en,
  output logic [1:0] wr_bank,
  output logic [3:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [1:0] bank,
  output logic       slow_mode,
  output logic       led,
  output logic       adc_en,
  output logic       fsm_rst_p,
  output logic       arm_p,
  output logic       adc_rst_p
);
  localparam logic [7:0] TERM      = 8'h7E;
  localparam logic [7:0] SYNC0     = 8'h40;
  localparam logic [3:0] ADDR_CTL  = 4'd14;
  localparam logic [3:0] ADDR_BANK = 4'd15;
  localparam int         HDR_LEN   = 5;

  typedef enum logic [1:0] {S_HDR, S_HI, S_LO} state_t;

  state_t     st;
  logic [2:0] hidx;
  logic [7:0] hi_q;

  function automatic logic [7:0] hdr_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h40;
      3'd1:    return 8'h4C;
      3'd2:    return 8'h44;
      3'd3:    return 8'h53;
      default: return 8'h7E;
    endcase
  endfunction

  wire [15:0] word    = {hi_q, rx_data};
  wire        word_ok = !word[15] && !word[7] && (word[6] != word[5]) && (word[14] != word[13]);
  wire [7:0]  val     = {word[13:12], word[5:0]};
  wire [3:0]  adr     = word[11:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HDR;
      hidx      <= '0;
      hi_q      <= '0;
      wr_en     <= 1'b0;
      wr_bank   <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      bank      <= '0;
      slow_mode <= 1'b0;
      led       <= 1'b0;
      adc_en    <= 1'b0;
      fsm_rst_p <= 1'b0;
      arm_p     <= 1'b0;
      adc_rst_p <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      fsm_rst_p <= 1'b0;
      arm_p     <= 1'b0;
      adc_rst_p <= 1'b0;
      if (rx_valid) begin
        case (st)
          S_HDR: begin
            if (rx_data == hdr_byte(hidx)) begin
              if (hidx == 3'(HDR_LEN - 1)) begin
                st   <= S_HI;
                hidx <= '0;
              end else begin
                hidx <= hidx + 3'd1;
              end
            end else begin
              hidx <= (rx_data == SYNC0) ? 3'd1 : 3'd0;
            end
          end
          S_HI: begin
            if (rx_data == TERM) begin
              st <= S_HDR;
            end else begin
              hi_q <= rx_data;
              st   <= S_LO;
            end
          end
          default: begin
            st <= S_HI;
            if (word_ok) begin
              wr_en   <= 1'b1;
              wr_bank <= bank;
              wr_addr <= adr;
              wr_data <= val;
              if (adr == ADDR_BANK) begin
                bank      <= val[1:0];
                slow_mode <= val[5];
              end
              if (adr == ADDR_CTL) begin
                led       <= val[7];
                adc_en    <= val[4];
                fsm_rst_p <= val[0];
                arm_p     <= val[1];
                adc_rst_p <= val[6];
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_frame_decoder_chk.sv
module cmd_frame_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [1:0] bank,
  input logic       slow_mode,
  input logic       led,
  input logic       adc_en,
  input logic       fsm_rst_p,
  input logic       arm_p,
  input logic       adc_rst_p
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R6
  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_en) |-> $past(rx_valid)); // R9
  AST_PULSE_WITH_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_rst_p || arm_p || adc_rst_p) |-> (wr_en && wr_addr == 4'd14)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_rst_p || arm_p || adc_rst_p) |=> !(fsm_rst_p || arm_p || adc_rst_p)); // R8
  AST_LEVEL_ONLY_BY_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(led) && $stable(adc_en)) |-> (wr_en && wr_addr == 4'd14)); // R8
  AST_BANK_ONLY_BY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(bank) && $stable(slow_mode)) |-> (wr_en && wr_addr == 4'd15)); // R7
endmodule

bind cmd_frame_decoder cmd_frame_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .wr_en(wr_en), .wr_addr(wr_addr),
  .bank(bank), .slow_mode(slow_mode), .led(led), .adc_en(adc_en),
  .fsm_rst_p(fsm_rst_p), .arm_p(arm_p), .adc_rst_p(adc_rst_p)
);

// File: tb/test_cmd_frame_decoder.sv
module test_cmd_frame_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic wr_en, slow_mode, led, adc_en, fsm_rst_p, arm_p, adc_rst_p;
  logic [1:0] wr_bank, bank;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;

  cmd_frame_decoder i_cmd_frame_decoder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank(bank), .slow_mode(slow_mode), .led(led), .adc_en(adc_en),
    .fsm_rst_p(fsm_rst_p), .arm_p(arm_p), .adc_rst_p(adc_rst_p)
  );

  always #5 clk = ~clk;

  int total = 0;
  int fails = 0;
  int m_st = 0;
  int m_idx = 0;
  logic [7:0] m_hi = '0;
  logic [1:0] m_bank = '0;
  logic m_slow = 0, m_led = 0, m_adc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] a, input logic [7:0] v);
    return {1'b0, ~v[7], v[7:6], a, 1'b0, ~v[5], v[5:0]};
  endfunction

  function automatic logic [7:0] hdr(input int i);
    case (i)
      0: return 8'h40;
      1: return 8'h4C;
      2: return 8'h44;
      3: return 8'h53;
      default: return 8'h7E;
    endcase
  endfunction

  task automatic send(input logic [7:0] b);
    logic e_wr, e_f, e_a, e_r;
    logic [1:0] e_bank;
    logic [3:0] e_addr;
    logic [7:0] e_val;
    logic [15:0] w;
    string tag;
    e_wr = 0; e_f = 0; e_a = 0; e_r = 0; e_bank = m_bank; e_addr = 0; e_val = 0;
    if (m_st == 0) begin
      tag = "R2";
      if (b == hdr(m_idx)) begin
        if (m_idx == 4) begin m_st = 1; m_idx = 0; end else m_idx++;
      end else m_idx = (b == 8'h40) ? 1 : 0;
    end else if (m_st == 1) begin
      tag = "R5";
      if (b == 8'h7E) m_st = 0; else begin m_hi = b; m_st = 2; end
    end else begin
      w = {m_hi, b};
      m_st = 1;
      if (w[15] == 0 && w[7] == 0 && w[6] == ~w[5] && w[14] == ~w[13]) begin
        tag = "R3";
        e_wr = 1; e_addr = w[11:8]; e_val = {w[13:12], w[5:0]};
        if (e_addr == 15) begin m_bank = e_val[1:0]; m_slow = e_val[5]; end
        if (e_addr == 14) begin
          m_led = e_val[7]; m_adc = e_val[4];
          e_f = e_val[0]; e_a = e_val[1]; e_r = e_val[6];
        end
      end else tag = "R4";
    end
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_data = $urandom;
    chk(wr_en == e_wr, {tag, " R6 wr_en"}, wr_en, e_wr);
    if (e_wr) begin
      chk(wr_addr == e_addr && wr_data == e_val, "R3 addr/data", {wr_addr, wr_data}, {e_addr, e_val});
      chk(wr_bank == e_bank, "R7 wr_bank", wr_bank, e_bank);
    end
    chk({fsm_rst_p, arm_p, adc_rst_p} == {e_f, e_a, e_r}, "R8 pulses", {fsm_rst_p, arm_p, adc_rst_p}, {e_f, e_a, e_r});
    chk({led, adc_en} == {m_led, m_adc}, "R8 levels", {led, adc_en}, {m_led, m_adc});
    chk({bank, slow_mode} == {m_bank, m_slow}, "R7 bank", {bank, slow_mode}, {m_bank, m_slow});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_data = $urandom;
      chk(!wr_en && !fsm_rst_p && !arm_p && !adc_rst_p, "R9 idle", wr_en, 0);
    end
  endtask

  task automatic send_hdr();
    for (int i = 0; i < 5; i++) send(hdr(i));
  endtask

  task automatic send_word(input logic [15:0] w);
    send(w[15:8]);
    send(w[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({wr_en, fsm_rst_p, arm_p, adc_rst_p, bank, slow_mode, led, adc_en} == 0, "R1 reset",
        {wr_en, fsm_rst_p, arm_p, adc_rst_p, bank, slow_mode, led, adc_en}, 0);
    rst_n = 1'b1;
    idle(2);
    // R2: words before a header are ignored, 0x40 resync
    send_word(enc(4'd3, 8'h55));
    send(8'h40); send(8'h40); send(8'h4C); send(8'h44); send(8'h53); send(8'h7E);
    // R7: bank switch then write
    send_word(enc(4'd15, 8'h22));
    send_word(enc(4'd4, 8'hA5));
    // R8: control write with all bits set, then cleared
    send_word(enc(4'd14, 8'hFF));
    send_word(enc(4'd14, 8'h00));
    // R4: each check bit broken
    send_word(enc(4'd1, 8'h3C) ^ 16'h0040);
    send_word(enc(4'd1, 8'h3C) ^ 16'h4000);
    send_word(enc(4'd1, 8'h3C) ^ 16'h0080);
    send_word(enc(4'd1, 8'h3C) ^ 16'h8000);
    send_word(enc(4'd2, 8'hC3));
    // R5: terminator, then word-like bytes ignored
    send(8'h7E);
    send_word(enc(4'd9, 8'h11));
    // R9: idle noise mid-packet
    send_hdr();
    send(enc(4'd12, 8'h81) >> 8);
    idle(4);
    send(enc(4'd12, 8'h81) & 16'hFF);
    send(8'h7E);
    for (int p = 0; p < 300; p++) begin
      idle($urandom % 3);
      for (int i = 0; i < 5; i++)
        send(($urandom % 10 == 0) ? 8'($urandom) : hdr(i));
      for (int k = 0; k < 1 + int'($urandom % 4); k++) begin
        logic [15:0] w;
        w = enc(4'($urandom), 8'($urandom));
        if ($urandom % 6 == 0) w ^= 16'h1 << (($urandom % 2) ? 6 + 8 * ($urandom % 2) : 7 + 8 * ($urandom % 2));
        send_word(w);
        if ($urandom % 4 == 0) idle(1);
      end
      send(8'h7E);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule